// File: doc/BRIEF.md
# Parallel Set-Bit Counter with Cross-Checked Datapaths

This block reports how many bits are set in a 32-bit operand. Three independent counting datapaths run side by side on the same operand: a serial accumulation of single bits, a packed-field reduction that works on bit pairs, then nibbles, then bytes inside one word, and a byte lookup that reads four copies of a 256-entry table at once. A two-bit select chooses which datapath feeds the result register.

An operand offered with `in_valid` is counted in one cycle and the chosen count is registered. `out_valid` rises in the next cycle for that one result. Because all three datapaths always work, the block also compares them. A registered flag reports any disagreement alongside the result it belongs to, so the block can serve as a self-checking reference or as a bench for comparing the styles.

Top module: `popcnt_multi`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `out_count` and `out_mismatch` to zero at the next rising clock edge.
- R2: An operand sampled with `in_valid` high produces `out_valid` high in the next cycle only. A cycle with `in_valid` low is followed by `out_valid` low.
- R3: `style_sel` = 2'b00 selects the serial bit-accumulation datapath, and `out_count` equals the number of ones in the operand.
- R4: `style_sel` = 2'b01 selects the packed pair/nibble/byte reduction datapath, and `out_count` equals the number of ones.
- R5: `style_sel` = 2'b10 selects the four-table byte lookup datapath, and `out_count` equals the number of ones.
- R6: `style_sel` = 2'b11 returns the packed reduction result, which is the correct count.
- R7: The count covers the full range 0 to 32. An all-zero operand gives 0 and an all-ones operand gives 32 under every select value.
- R8: `out_mismatch` is high only in a cycle where `out_valid` is high, and it stays low whenever the three datapaths agree.
- R9: While `in_valid` is low, `out_count` keeps the last registered value.
- R10: Operands on consecutive cycles, each with its own select value, each produce their own count in successive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Operand whose ones are counted |
| style_sel | input | 2 | Datapath select: 00 serial, 01 packed, 10 lookup, 11 packed |
| out_valid | output | 1 | Registered count is new this cycle |
| out_count | output | 6 | Registered number of set bits (0 to 32) |
| out_mismatch | output | 1 | Datapaths disagreed on this result |

## Verification
The result strobe and the disagreement flag come from the same register stage, so each result has its own comparison in the same cycle. The bench feeds every table operand under all four select codes. For each one it checks that `out_valid` is high, that the count matches the expected value, and that `out_mismatch` stays low in that same cycle. A back-to-back stream that changes the select on every cycle checks that each strobe carries the count for its own operand and not the previous one. Idle cycles and a reset in the middle of a stream then show that both the strobe and the flag drop.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        STYLE_SERIAL = 2'b00,
        STYLE_PACKED = 2'b01,
        STYLE_LOOKUP = 2'b10,
        STYLE_ALT    = 2'b11
    } style_e;

    typedef logic [3:0] byte_tbl_t [256];

    // Popcount of one byte, used only to fill the constant tables.
    function automatic logic [3:0] ones_in_byte(input logic [7:0] b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + 4'(b[i]);
        end
        return n;
    endfunction

    function automatic byte_tbl_t build_byte_tbl();
        byte_tbl_t t;
        for (int idx = 0; idx < 256; idx++) begin
            t[idx] = ones_in_byte(8'(idx));
        end
        return t;
    endfunction

endpackage

// File: rtl/popcnt_serial.sv
module popcnt_serial #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [CNT_W-1:0]  count_o
);
    // Each bit is added as a number; no per-bit branch.
    always_comb begin
        logic [CNT_W-1:0] acc_d;
        acc_d = '0;
        for (int i = 0; i < DATA_W; i++) begin
            acc_d = acc_d + CNT_W'(word_i[i]);
        end
        count_o = acc_d;
    end
endmodule

// File: rtl/popcnt_packed.sv
module popcnt_packed #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1),
    localparam int unsigned NBYTE = DATA_W / 8
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam logic [DATA_W-1:0] M_PAIR = {NBYTE{8'h55}};
    localparam logic [DATA_W-1:0] M_NIB  = {NBYTE{8'h33}};
    localparam logic [DATA_W-1:0] M_BYTE = {NBYTE{8'h0F}};
    localparam logic [DATA_W-1:0] SPREAD = {NBYTE{8'h01}};

    logic [DATA_W-1:0] pair_d, nib_d, byte_d, prod_d;
    logic [7:0]        total_d;
    logic              unused_low;

    always_comb begin
        pair_d  = word_i - ((word_i >> 1) & M_PAIR);
        nib_d   = ((pair_d >> 2) & M_NIB) + (pair_d & M_NIB);
        byte_d  = (nib_d + (nib_d >> 4)) & M_BYTE;
        // Keep only the low word of the product; the top byte holds the sum.
        prod_d  = byte_d * SPREAD;
        total_d = prod_d[DATA_W-1 -: 8];
        count_o = total_d[CNT_W-1:0];
    end

    assign unused_low = ^{prod_d[DATA_W-9:0], total_d[7:CNT_W]};
endmodule

// File: rtl/popcnt_lookup.sv
module popcnt_byte_rom (
    input  logic [7:0] addr_i,
    output logic [3:0] ones_o
);
    import popcnt_pkg::*;
    localparam byte_tbl_t TBL = build_byte_tbl();
    assign ones_o = TBL[addr_i];
endmodule

module popcnt_lookup #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1),
    localparam int unsigned NBYTE = DATA_W / 8
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [CNT_W-1:0]  count_o
);
    logic [3:0] part_w [NBYTE];

    // One table copy per byte lane so all lanes resolve in one cycle.
    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        popcnt_byte_rom u_rom (
            .addr_i (word_i[8*g +: 8]),
            .ones_o (part_w[g])
        );
    end

    always_comb begin
        logic [CNT_W-1:0] sum_d;
        sum_d = '0;
        for (int i = 0; i < NBYTE; i++) begin
            sum_d = sum_d + CNT_W'(part_w[i]);
        end
        count_o = sum_d;
    end
endmodule

// File: rtl/popcnt_multi.sv
module popcnt_multi #(
    parameter int unsigned DATA_W = popcnt_pkg::WORD_W,
    parameter bit          XCHECK = 1'b1,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        style_sel,
    output logic              out_valid,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_mismatch
);
    import popcnt_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] count;
        logic             mismatch;
    } state_t;

    logic [CNT_W-1:0] ser_w, pak_w, lut_w;
    logic             disagree_w;
    state_t           st_d, st_q;

    popcnt_serial #(.DATA_W(DATA_W)) u_serial (.word_i(in_data), .count_o(ser_w));
    popcnt_packed #(.DATA_W(DATA_W)) u_packed (.word_i(in_data), .count_o(pak_w));
    popcnt_lookup #(.DATA_W(DATA_W)) u_lookup (.word_i(in_data), .count_o(lut_w));

    if (XCHECK) begin : g_xchk
        assign disagree_w = (ser_w != pak_w) || (pak_w != lut_w);
    end else begin : g_noxchk
        assign disagree_w = 1'b0;
    end

    always_comb begin
        st_d          = st_q;
        st_d.valid    = in_valid;
        st_d.mismatch = in_valid && disagree_w;
        if (in_valid) begin
            unique case (style_e'(style_sel))
                STYLE_SERIAL: st_d.count = ser_w;
                STYLE_PACKED: st_d.count = pak_w;
                STYLE_LOOKUP: st_d.count = lut_w;
                default:      st_d.count = pak_w;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_count    = st_q.count;
    assign out_mismatch = st_q.mismatch;
endmodule

// File: rtl/popcnt_multi_chk.sv
module popcnt_multi_chk #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [CNT_W-1:0]  out_count,
    input logic              out_mismatch
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_count == '0 && !out_mismatch));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    count_right_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (32'(out_count) == 32'($countones($past(in_data)))));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (32'(out_count) <= DATA_W));

    // R8
    flag_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_mismatch |-> out_valid);

    // R8
    no_disagree_chk: assert property (@(posedge clk) disable iff (rst)
        !out_mismatch);

    // R9
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_count));
endmodule

bind popcnt_multi popcnt_multi_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_count    (out_count),
    .out_mismatch (out_mismatch)
);

// File: tb/tb_popcnt_multi.sv
module tb_popcnt_multi;
    localparam int NVEC = 13;
    localparam logic [31:0] VEC_DATA [NVEC] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000,
        32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_FFFF, 32'hF0F0_F0F0,
        32'h1234_5678, 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h00FF_00FF,
        32'h8000_0001
    };
    localparam int VEC_EXP [NVEC] = '{
        0, 32, 1, 1, 16, 16, 16, 16, 13, 24, 31, 16, 2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  style_sel = 2'b00;
    logic        out_valid;
    logic [5:0]  out_count;
    logic        out_mismatch;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    popcnt_multi dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .style_sel    (style_sel),
        .out_valid    (out_valid),
        .out_count    (out_count),
        .out_mismatch (out_mismatch)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string style_req(input logic [1:0] s);
        case (s)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [5:0] held;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_count), 0);
        check("R1", int'(out_mismatch), 0);
        rst = 1'b0;

        // Vector table under every select code
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < NVEC; v++) begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_data   = VEC_DATA[v];
                style_sel = 2'(s);
                @(negedge clk);
                in_valid  = 1'b0;
                check("R2", int'(out_valid), 1);
                check(style_req(2'(s)), int'(out_count), VEC_EXP[v]);
                check("R8", int'(out_mismatch), 0);
                if (v == 0 || v == 1) check("R7", int'(out_count), VEC_EXP[v]);
            end
        end

        // R2 / R9: idle cycle drops strobe and holds the count
        @(negedge clk);
        held = out_count;
        in_data = 32'h0000_00FF;
        style_sel = 2'b10;
        @(negedge clk);
        check("R2", int'(out_valid), 0);
        check("R9", int'(out_count), int'(held));
        check("R8", int'(out_mismatch), 0);

        // R10: back-to-back stream with changing select
        in_valid = 1'b1; in_data = 32'h0000_000F; style_sel = 2'b00;
        @(negedge clk);
        check("R10", int'(out_count), 4);
        check("R10", int'(out_valid), 1);
        in_data = 32'hFFFF_FFFF; style_sel = 2'b01;
        @(negedge clk);
        check("R10", int'(out_count), 32);
        in_data = 32'h0101_0101; style_sel = 2'b10;
        @(negedge clk);
        check("R10", int'(out_count), 4);
        in_data = 32'h0000_0000; style_sel = 2'b11;
        @(negedge clk);
        check("R10", int'(out_count), 0);
        check("R10", int'(out_valid), 1);
        in_data = 32'hFFFF_0000; style_sel = 2'b10;
        @(negedge clk);
        check("R10", int'(out_count), 16);

        // R1: reset while a stream is running
        rst = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_count), 0);
        check("R1", int'(out_mismatch), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", int'(out_valid), 0);
        check("R9", int'(out_count), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule